// File: doc/BRIEF.md
# Stepped Power-Down Clock Post-Divider

This block takes a fast VCO clock and divides it by 1, 2, 4 or 8, chosen by a 2-bit code, to give one output clock with an even duty cycle. Divide by 1 is a glitch-free bypass of the divider counter. All other ratios come from a half-period counter that toggles a registered output.

When the power-down input is raised, the block does not stop or gate the clock. It slows the output in stages until the period is sixteen times the programmed period. Each stage doubles the extra division and lasts a set number of cycles of a slower reference clock. When power-down is dropped, the output speeds up again in four halving stages. The stage level lives in the reference domain as a Gray-coded counter. Each bit of that counter crosses into the VCO domain through a flop synchronizer. The divider takes on a new ratio only where an output period ends, so no runt or shortened phase ever appears.

Top module: `vco_postdiv`

## Requirements
- R1: The ratio code selects the steady output period: code 00 gives 1, code 01 gives 2, code 10 gives 4 and code 11 gives 8 VCO periods.
- R2: Every output period has a high phase and a low phase of equal length, at every ratio and during every transition.
- R3: While power-down is held, the output settles to a period of 16 times the programmed period and goes no slower.
- R4: After power-down rises, the output period passes through 2, 4, 8 and 16 times the programmed period in that order. Each intermediate level lasts STEP_REF_CYCLES reference cycles, give or take one output period.
- R5: After power-down falls, the output returns to the programmed period in four halving steps: 16, 8, 4, 2, 1 times.
- R6: A change of ratio, whether from the code or from a power-down step, takes effect only at the end of a complete output period. Every output period is therefore a whole power-of-two number of VCO periods.
- R7: The divide-by-1 bypass is entered only at the end of a low phase, and left with the divided output starting high, so no glitch occurs at either switch.
- R8: While reset is high, the output is low. Reset clears the power-down stage to full speed, so the first period after reset is at the programmed ratio.
- R9: If power-down is released before the slowest level is reached, the stages reverse from the level already reached. No further slowing step follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vco_clk | input | 1 | Fast source clock to be divided |
| ref_clk | input | 1 | Slow clock that paces power-down stages |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| ratio_sel | input | RATIO_W | Ratio code; the divide ratio is 2 to the power of this code |
| pwr_dn | input | 1 | Power-down request, taken in through a reference-domain synchronizer |
| clk_out | output | 1 | Divided output clock |

## Verification
The bench builds the block with STEP_REF_CYCLES set to 20 and a reference clock eight times slower than the VCO clock. Each stage then lasts 1.6 us, which is longer than the slowest output period of 1.28 us. Every intermediate ratio therefore appears as at least one full period, so the bench can check the whole stage sequence and the stage spacing. With these settings, a reversal in the middle of a ramp and entry into and exit from bypass can also be reached within a few microseconds.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

  localparam int GW = 8;

  function automatic logic [GW-1:0] bin2gray(input logic [GW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [GW-1:0] gray2bin(input logic [GW-1:0] g);
    logic [GW-1:0] b;
    b[GW-1] = g[GW-1];
    for (int i = GW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/pdiv_sync.sv
module pdiv_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pdiv_pacer.sv
module pdiv_pacer #(
  parameter int LVL_MAX     = 4,
  parameter int LVL_W       = 3,
  parameter int STEP_CYC    = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             ref_clk,
  input  logic             rst,
  input  logic             pwr_dn,
  output logic [LVL_W-1:0] lvl_gray
);
  localparam int PACE_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;

  logic              pd_s;
  logic [PACE_W-1:0] pace;
  logic [LVL_W-1:0]  lvl, lvl_nxt;
  logic              at_target;

  pdiv_sync #(.W(1), .STAGES(SYNC_STAGES)) u_pd_sync (
    .clk(ref_clk), .rst(rst), .d(pwr_dn), .q(pd_s)
  );

  assign at_target = pd_s ? (lvl == LVL_W'(LVL_MAX)) : (lvl == '0);

  always_comb begin
    lvl_nxt = lvl;
    if (!at_target && pace == PACE_W'(STEP_CYC - 1))
      lvl_nxt = pd_s ? lvl + LVL_W'(1) : lvl - LVL_W'(1);
  end

  always_ff @(posedge ref_clk) begin
    if (rst) begin
      pace     <= '0;
      lvl      <= '0;
      lvl_gray <= '0;
    end else begin
      if (at_target || pace == PACE_W'(STEP_CYC - 1)) pace <= '0;
      else                                            pace <= pace + PACE_W'(1);
      lvl      <= lvl_nxt;
      lvl_gray <= LVL_W'(pdiv_pkg::bin2gray(8'(lvl_nxt)));
    end
  end
endmodule

// File: rtl/pdiv_core.sv
module pdiv_core #(
  parameter int EXP_W = 3,
  parameter int CNT_W = 7
) (
  input  logic             vco_clk,
  input  logic             rst,
  input  logic [EXP_W-1:0] new_exp,
  output logic             clk_out
);
  logic [EXP_W-1:0] cur_exp;
  logic [CNT_W-1:0] cnt, half_m1;
  logic             div_q, byp, prd_end;

  assign half_m1 = (CNT_W'(1) << (cur_exp - EXP_W'(1))) - CNT_W'(1);
  assign prd_end = byp || (!div_q && cnt == half_m1);

  always_ff @(posedge vco_clk) begin
    if (rst) begin
      cur_exp <= EXP_W'(1);
      cnt     <= '0;
      div_q   <= 1'b0;
      byp     <= 1'b0;
    end else if (byp) begin
      div_q <= 1'b1;
      if (new_exp != '0) begin
        byp     <= 1'b0;
        cnt     <= '0;
        cur_exp <= new_exp;
      end
    end else if (cnt == half_m1) begin
      cnt <= '0;
      if (div_q) begin
        div_q <= 1'b0;
      end else begin
        div_q   <= 1'b1;
        cur_exp <= new_exp;
        if (new_exp == '0) byp <= 1'b1;
      end
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign clk_out = byp ? vco_clk : div_q;
endmodule

// File: rtl/vco_postdiv.sv
module vco_postdiv #(
  parameter int RATIO_W         = 2,
  parameter int LVL_MAX         = 4,
  parameter int STEP_REF_CYCLES = 1,
  parameter int SYNC_STAGES     = 2
) (
  input  logic               vco_clk,
  input  logic               ref_clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] ratio_sel,
  input  logic               pwr_dn,
  output logic               clk_out
);
  localparam int EXP_MAX = (1 << RATIO_W) - 1 + LVL_MAX;
  localparam int EXP_W   = $clog2(EXP_MAX + 1);
  localparam int LVL_W   = $clog2(LVL_MAX + 1);
  localparam int CNT_W   = EXP_MAX;

  logic [LVL_W-1:0] gray_ref, gray_vco, lvl_v;
  logic [EXP_W-1:0] new_exp;

  pdiv_pacer #(
    .LVL_MAX(LVL_MAX), .LVL_W(LVL_W),
    .STEP_CYC(STEP_REF_CYCLES), .SYNC_STAGES(SYNC_STAGES)
  ) u_pacer (
    .ref_clk(ref_clk), .rst(rst), .pwr_dn(pwr_dn), .lvl_gray(gray_ref)
  );

  pdiv_sync #(.W(LVL_W), .STAGES(SYNC_STAGES)) u_lvl_sync (
    .clk(vco_clk), .rst(rst), .d(gray_ref), .q(gray_vco)
  );

  assign lvl_v   = LVL_W'(pdiv_pkg::gray2bin(8'(gray_vco)));
  assign new_exp = EXP_W'(ratio_sel) + EXP_W'(lvl_v);

  pdiv_core #(.EXP_W(EXP_W), .CNT_W(CNT_W)) u_core (
    .vco_clk(vco_clk), .rst(rst), .new_exp(new_exp), .clk_out(clk_out)
  );
endmodule

// File: rtl/vco_postdiv_chk.sv
module vco_postdiv_chk #(
  parameter int EXP_W   = 3,
  parameter int CNT_W   = 7,
  parameter int LVL_W   = 3,
  parameter int LVL_MAX = 4
) (
  input logic             vco_clk,
  input logic             rst,
  input logic             div_q,
  input logic             byp,
  input logic             prd_end,
  input logic [EXP_W-1:0] cur_exp,
  input logic [LVL_W-1:0] lvl_v
);
  localparam int HW = CNT_W + 1;
  logic [HW-1:0] hi_run;
  logic          rst_d;

  always_ff @(posedge vco_clk) begin
    rst_d <= rst;
    if (rst) hi_run <= '0;
    else     hi_run <= (div_q && !byp) ? hi_run + HW'(1) : '0;
  end

  always @(posedge vco_clk) begin
    if (rst_d && rst) AST_RST_OUT_LOW: assert (!div_q && !byp); // R8
  end

  AST_LVL_RANGE: assert property (@(posedge vco_clk) disable iff (rst)
    lvl_v <= LVL_W'(LVL_MAX)); // R3

  AST_LVL_ONE_STEP: assert property (@(posedge vco_clk) disable iff (rst)
    (lvl_v == $past(lvl_v)) || (lvl_v == $past(lvl_v) + LVL_W'(1)) ||
    (lvl_v + LVL_W'(1) == $past(lvl_v))); // R4

  AST_EXP_HOLD: assert property (@(posedge vco_clk) disable iff (rst)
    !prd_end |=> $stable(cur_exp)); // R6

  AST_HALF_PHASE: assert property (@(posedge vco_clk) disable iff (rst)
    (!div_q && !byp && hi_run != '0) |-> (hi_run == (HW'(1) << (cur_exp - EXP_W'(1))))); // R2

  AST_BYP_ENTER: assert property (@(posedge vco_clk) disable iff (rst)
    $rose(byp) |-> $past(!div_q)); // R7

  AST_BYP_EXIT: assert property (@(posedge vco_clk) disable iff (rst)
    $fell(byp) |-> div_q); // R7
endmodule

bind vco_postdiv vco_postdiv_chk #(
  .EXP_W(EXP_W), .CNT_W(CNT_W), .LVL_W(LVL_W), .LVL_MAX(LVL_MAX)
) u_chk (
  .vco_clk(vco_clk), .rst(rst), .div_q(u_core.div_q), .byp(u_core.byp),
  .prd_end(u_core.prd_end), .cur_exp(u_core.cur_exp), .lvl_v(lvl_v)
);

// File: tb/vco_postdiv_test.sv
`timescale 1ns/1ps
module vco_postdiv_test;
  localparam int STEP = 20;

  logic       vco_clk = 0, ref_clk = 0, rst = 1, pwr_dn = 0;
  logic [1:0] ratio_sel = 2'b10;
  logic       clk_out;

  always #5  vco_clk = ~vco_clk;
  always #40 ref_clk = ~ref_clk;

  vco_postdiv #(.STEP_REF_CYCLES(STEP)) uut (
    .vco_clk(vco_clk), .ref_clk(ref_clk), .rst(rst),
    .ratio_sel(ratio_sel), .pwr_dn(pwr_dn), .clk_out(clk_out)
  );

  int      n_chk = 0, n_bad = 0;
  bit      done = 0;
  int      exp_q[$];
  string   req_q[$];
  int      rec_per[$];
  realtime rec_t[$];
  bit      rec_en = 0, mon_en = 0, have_r = 0;
  realtime tr, tf;

  task automatic check(string req, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic int legal(int p);
    for (int k = 0; k < 8; k++) if (p == 10 * (1 << k)) return 1;
    return 0;
  endfunction

  // monitor: measures each output period and scores it
  always @(negedge clk_out) tf = $realtime;
  always @(posedge clk_out) begin
    realtime now;
    int per, hi;
    now = $realtime;
    if (have_r && mon_en) begin
      per = int'(now - tr);
      hi  = int'(tf - tr);
      check("R6 whole power-of-two period", legal(per), 1);
      check("R2 equal phases", 2 * hi, per);
      if (rec_en) begin
        rec_per.push_back(per);
        rec_t.push_back(tr);
      end
      if (exp_q.size() > 0) begin
        check(req_q[0], per, exp_q[0]);
        void'(exp_q.pop_front());
        void'(req_q.pop_front());
      end
    end
    tr = now;
    have_r = 1;
  end

  // driver: queue expected periods, wait for the monitor to consume them
  task automatic expect_n(string req, int per, int n);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(per);
      req_q.push_back(req);
    end
    wait (exp_q.size() == 0);
    #3;
  endtask

  task automatic rec_start();
    rec_per.delete();
    rec_t.delete();
    rec_en = 1;
  endtask

  // collapse recorded periods into runs and compare with the expected run list
  task automatic runs_check(string req, int expv[5], bit spacing);
    int      d[$];
    realtime ds[$];
    for (int i = 0; i < rec_per.size(); i++)
      if (d.size() == 0 || d[d.size()-1] != rec_per[i]) begin
        d.push_back(rec_per[i]);
        ds.push_back(rec_t[i]);
      end
    check({req, " run count"}, d.size(), 5);
    for (int k = 0; k < 5; k++)
      if (k < d.size()) check({req, " run period"}, d[k], expv[k]);
    if (spacing && d.size() == 5)
      for (int k = 1; k < 4; k++) begin
        int dur;
        dur = int'(ds[k+1] - ds[k]);
        check("R4 level length near 1600ns", (dur > 1250 && dur < 1950) ? 1 : 0, 1);
      end
  endtask

  initial begin
    #1_500_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    // R8: output low while in reset
    for (int i = 0; i < 5; i++) begin
      @(negedge vco_clk);
      check("R8 low in reset", clk_out, 0);
    end
    mon_en = 1;
    exp_q.push_back(40);
    req_q.push_back("R8 first period after reset");
    #3 rst = 0;
    wait (exp_q.size() == 0);
    #3;

    // R1: each ratio code
    for (int c = 0; c < 4; c++) begin
      ratio_sel = 2'(c);
      #2000;
      expect_n("R1 ratio period", 10 << c, 4);
    end

    // R3/R4/R5 at ratio 01 (period 20)
    ratio_sel = 2'b01;
    #2000;
    rec_start();
    pwr_dn = 1;
    #9000;
    expect_n("R3 slowed to x16", 320, 3);
    rec_en = 0;
    runs_check("R4 down ramp", '{20, 40, 80, 160, 320}, 1);
    rec_start();
    pwr_dn = 0;
    #9000;
    expect_n("R5 restored", 20, 3);
    rec_en = 0;
    runs_check("R5 up ramp", '{320, 160, 80, 40, 20}, 0);

    // R3/R5 at ratio 11 (period 80)
    ratio_sel = 2'b11;
    #2000;
    pwr_dn = 1;
    #9000;
    expect_n("R3 slowed to x16 at ratio 11", 1280, 2);
    pwr_dn = 0;
    #9000;
    expect_n("R5 restored at ratio 11", 80, 2);

    // R9 reversal mid-ramp, R7 bypass exit and re-entry at ratio 00
    ratio_sel = 2'b00;
    #2000;
    rec_start();
    pwr_dn = 1;
    #4200;
    pwr_dn = 0;
    #6000;
    expect_n("R7 bypass regained", 10, 4);
    rec_en = 0;
    runs_check("R9 reversal", '{10, 20, 40, 20, 10}, 0);

    // R8: reset in the middle of power-down clears the level
    ratio_sel = 2'b01;
    pwr_dn = 1;
    #9000;
    rst = 1;
    mon_en = 0;
    pwr_dn = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge vco_clk);
      check("R8 low in reset", clk_out, 0);
    end
    have_r = 0;
    mon_en = 1;
    #3 rst = 0;
    expect_n("R8 level cleared by reset", 20, 3);

    finish_run();
  end
endmodule